// File: doc/BRIEF.md
# Segment Translation and Protection Unit

This unit turns a two-part logical address, made of a segment number and an offset inside that segment, into a physical address. The lookup uses a small on-chip segment table. Every table entry holds four things: a base, which is the first physical address of the segment; a limit, which is the segment length; a valid flag; and three permission flags for read, write and execute. A separate length register sets how many segment numbers are legal.

Each translation request carries an access type. The unit answers one cycle after it accepts the request. The answer is either a physical address or a fault with a 2-bit cause code, which the kernel's trap logic consumes. Requests enter on a valid/ready stream and answers leave on a valid/ready stream.

The response stage holds one answer. While that answer is waiting and downstream does not accept it, the unit stops accepting new requests, and the held answer does not change. Software fills table entries and the length register through a plain register-write port.

Top module: `seg_xlate`

## Requirements
- R1: After reset the length register is 0, every entry is invalid, `rsp_valid` is 0 and `req_ready` is 1. A request issued right after reset faults with cause 00.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. Its answer shows on `rsp_*` with `rsp_valid`=1 after that same edge. `req_ready` equals `!rsp_valid || rsp_ready`.
- R3: While `rsp_valid`=1 and `rsp_ready`=0, `rsp_valid`, `rsp_fault`, `rsp_cause` and `rsp_paddr` hold their values. An answer is consumed on an edge where `rsp_valid` and `rsp_ready` are both 1.
- R4: A segment number greater than or equal to the length register faults with cause 00. This check has the highest priority.
- R5: A legal segment number whose entry has its valid flag at 0 faults with cause 01.
- R6: An offset greater than or equal to the entry's limit faults with cause 10. An offset of limit-1 passes this check.
- R7: The access type selects a permission flag: 00 read needs `perm[0]`, 01 write needs `perm[1]`, 10 execute needs `perm[2]`. Type 11 is always denied. A denied access faults with cause 11. This check has the lowest priority.
- R8: A request with no fault returns `rsp_fault`=0 and `rsp_paddr` = (base + offset) modulo 2^PA_W. A faulting request returns `rsp_fault`=1 and `rsp_paddr`=0.
- R9: A table write is applied at the clock edge where `wr_en`=1. `wr_sel`=0 writes entry `wr_idx` and `wr_sel`=1 writes the length register. A request accepted at that same edge is translated with the old contents, and later requests see the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can accept a request |
| req_seg | input | SEG_W (3) | Segment number |
| req_off | input | OFF_W (12) | Offset within the segment |
| req_acc | input | 2 | Access type: 00 read, 01 write, 10 execute, 11 reserved |
| rsp_valid | output | 1 | Answer present |
| rsp_ready | input | 1 | Downstream accepts the answer |
| rsp_fault | output | 1 | Answer is a fault |
| rsp_cause | output | 2 | Fault cause: 00 segment out of range, 01 invalid entry, 10 beyond limit, 11 permission |
| rsp_paddr | output | PA_W (16) | Physical address; 0 on a fault |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 writes a table entry, 1 writes the length register |
| wr_idx | input | SEG_W (3) | Entry index |
| wr_base | input | PA_W (16) | Entry base |
| wr_limit | input | OFF_W+1 (13) | Entry limit (segment length) |
| wr_ok | input | 1 | Entry valid flag |
| wr_perm | input | 3 | Entry permissions: bit0 read, bit1 write, bit2 execute |
| wr_len | input | SEG_W+1 (4) | Length register value |

## Verification
The bench targets fault priority by building requests that break several rules at once. A design that checks the rules in the wrong order reports the wrong cause code for these requests. The bench places offsets exactly at the limit and one below it, so an off-by-one compare either lets a byte past the segment through or rejects the last legal byte. It sends access type 11 to an entry that has every permission flag set, which catches any design that grants the reserved type. It also wraps the base-plus-offset sum past the top of the address range.

The bench holds back `rsp_ready` while another request waits, to check that the held answer stays frozen and that no request is lost or taken twice. It issues a table write and a request at the same edge, which exposes a table that forwards new contents into a request made in that cycle.

// File: rtl/seg_pkg.sv
package seg_pkg;
  localparam int SEG_W = 3;
  localparam int OFF_W = 12;
  localparam int PA_W  = 16;

  typedef enum logic [1:0] {
    ACC_RD  = 2'b00,
    ACC_WR  = 2'b01,
    ACC_EX  = 2'b10,
    ACC_RSV = 2'b11
  } acc_e;

  typedef enum logic [1:0] {
    CAUSE_RANGE = 2'b00,
    CAUSE_INVAL = 2'b01,
    CAUSE_LIMIT = 2'b10,
    CAUSE_PERM  = 2'b11
  } cause_e;

  typedef struct packed {
    logic [PA_W-1:0]  base;
    logic [OFF_W:0]   limit;
    logic             ok;
    logic [2:0]       perm;
  } seg_ent_t;
endpackage

// File: rtl/seg_table.sv
module seg_table
  import seg_pkg::*;
#(
  parameter int SW = SEG_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [SW-1:0] wr_idx,
  input  seg_ent_t      wr_ent,
  input  logic [SW:0]   wr_len,
  input  logic [SW-1:0] rd_idx,
  output seg_ent_t      rd_ent,
  output logic [SW:0]   len_q
);
  localparam int NSEG = 1 << SW;

  seg_ent_t ent_q [NSEG];

  for (genvar i = 0; i < NSEG; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst) begin
        ent_q[i] <= '0;
      end else if (wr_en && !wr_sel && (wr_idx == SW'(i))) begin
        ent_q[i] <= wr_ent;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                 len_q <= '0;
    else if (wr_en && wr_sel) len_q <= wr_len;
  end

  assign rd_ent = ent_q[rd_idx];

  // R9: a length write is visible at the next cycle
  a_r9_len_write: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel) |=> (len_q == $past(wr_len)));
endmodule

// File: rtl/seg_check.sv
module seg_check
  import seg_pkg::*;
#(
  parameter int SW = SEG_W,
  parameter int OW = OFF_W,
  parameter int PW = PA_W
) (
  input  logic [SW-1:0] seg,
  input  logic [OW-1:0] off,
  input  logic [1:0]    acc,
  input  logic [SW:0]   len,
  input  seg_ent_t      ent,
  output logic          fault,
  output logic [1:0]    cause,
  output logic [PW-1:0] paddr
);
  logic bad_range, bad_inval, bad_limit, bad_perm, allow;

  always_comb begin
    unique case (acc_e'(acc))
      ACC_RD:  allow = ent.perm[0];
      ACC_WR:  allow = ent.perm[1];
      ACC_EX:  allow = ent.perm[2];
      default: allow = 1'b0;
    endcase
  end

  assign bad_range = ({1'b0, seg} >= len);
  assign bad_inval = !ent.ok;
  assign bad_limit = ({1'b0, off} >= ent.limit);
  assign bad_perm  = !allow;

  always_comb begin
    fault = 1'b1;
    paddr = '0;
    if (bad_range)      cause = CAUSE_RANGE;
    else if (bad_inval) cause = CAUSE_INVAL;
    else if (bad_limit) cause = CAUSE_LIMIT;
    else if (bad_perm)  cause = CAUSE_PERM;
    else begin
      cause = CAUSE_RANGE;
      fault = 1'b0;
      paddr = ent.base + PW'(off);
    end
  end

  // R6: a passing translation always lies inside the segment
  always_comb begin
    if (!fault) a_r6_in_limit: assert ({1'b0, off} < ent.limit);
  end
endmodule

// File: rtl/seg_rsp_stage.sv
module seg_rsp_stage #(
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          in_fault,
  input  logic [1:0]    in_cause,
  input  logic [PW-1:0] in_paddr,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic          rsp_fault,
  output logic [1:0]    rsp_cause,
  output logic [PW-1:0] rsp_paddr
);
  logic take;

  assign req_ready = !rsp_valid || rsp_ready;
  assign take      = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_cause <= '0;
      rsp_paddr <= '0;
    end else if (take) begin
      rsp_valid <= 1'b1;
      rsp_fault <= in_fault;
      rsp_cause <= in_cause;
      rsp_paddr <= in_paddr;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R2: one-cycle latency
  a_r2_latency: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> rsp_valid);
  // R3: stalled answer is frozen
  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_fault)
      && $stable(rsp_cause) && $stable(rsp_paddr)));
  // R8: faults carry a zero address
  a_r8_zero_addr: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault) |-> (rsp_paddr == '0));
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_pkg::*;
#(
  parameter int SW = SEG_W,
  parameter int OW = OFF_W,
  parameter int PW = PA_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [SW-1:0] req_seg,
  input  logic [OW-1:0] req_off,
  input  logic [1:0]    req_acc,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic          rsp_fault,
  output logic [1:0]    rsp_cause,
  output logic [PW-1:0] rsp_paddr,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [SW-1:0] wr_idx,
  input  logic [PW-1:0] wr_base,
  input  logic [OW:0]   wr_limit,
  input  logic          wr_ok,
  input  logic [2:0]    wr_perm,
  input  logic [SW:0]   wr_len
);
  seg_ent_t        wr_ent, rd_ent;
  logic [SW:0]     tbl_len;
  logic            c_fault;
  logic [1:0]      c_cause;
  logic [PW-1:0]   c_paddr;

  assign wr_ent = '{base: wr_base, limit: wr_limit, ok: wr_ok, perm: wr_perm};

  seg_table #(.SW(SW)) u_tbl (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_idx(wr_idx),
    .wr_ent(wr_ent), .wr_len(wr_len),
    .rd_idx(req_seg), .rd_ent(rd_ent), .len_q(tbl_len)
  );

  seg_check #(.SW(SW), .OW(OW), .PW(PW)) u_chk (
    .seg(req_seg), .off(req_off), .acc(req_acc),
    .len(tbl_len), .ent(rd_ent),
    .fault(c_fault), .cause(c_cause), .paddr(c_paddr)
  );

  seg_rsp_stage #(.PW(PW)) u_rsp (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready),
    .in_fault(c_fault), .in_cause(c_cause), .in_paddr(c_paddr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_fault(rsp_fault), .rsp_cause(rsp_cause), .rsp_paddr(rsp_paddr)
  );

  // R4: an out-of-range segment number always reports cause 00
  a_r4_range_first: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && ({1'b0, req_seg} >= tbl_len))
      |=> (rsp_fault && rsp_cause == 2'b00));
endmodule

// File: tb/sim_seg_xlate.sv
module sim_seg_xlate;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, rsp_ready = 1'b1;
  logic [2:0]  req_seg = '0;
  logic [11:0] req_off = '0;
  logic [1:0]  req_acc = '0;
  logic        wr_en = 1'b0, wr_sel = 1'b0, wr_ok = 1'b0;
  logic [2:0]  wr_idx = '0, wr_perm = '0;
  logic [15:0] wr_base = '0;
  logic [12:0] wr_limit = '0;
  logic [3:0]  wr_len = '0;
  logic        req_ready, rsp_valid, rsp_fault;
  logic [1:0]  rsp_cause;
  logic [15:0] rsp_paddr;

  int checks = 0, failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  seg_xlate u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_seg(req_seg), .req_off(req_off), .req_acc(req_acc),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_fault(rsp_fault),
    .rsp_cause(rsp_cause), .rsp_paddr(rsp_paddr),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_idx(wr_idx), .wr_base(wr_base),
    .wr_limit(wr_limit), .wr_ok(wr_ok), .wr_perm(wr_perm), .wr_len(wr_len)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_rsp(input string tag, input logic f, input logic [1:0] c,
                         input logic [15:0] pa);
    chk({tag, " valid"}, {31'd0, rsp_valid}, 32'd1);
    chk({tag, " fault"}, {31'd0, rsp_fault}, {31'd0, f});
    chk({tag, " cause"}, {30'd0, rsp_cause}, {30'd0, c});
    chk({tag, " paddr"}, {16'd0, rsp_paddr}, {16'd0, pa});
  endtask

  task automatic put_ent(input logic [2:0] idx, input logic [15:0] b,
                         input logic [12:0] lim, input logic ok, input logic [2:0] p);
    @(negedge clk);
    wr_en = 1; wr_sel = 0; wr_idx = idx; wr_base = b; wr_limit = lim; wr_ok = ok; wr_perm = p;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic put_len(input logic [3:0] l);
    @(negedge clk);
    wr_en = 1; wr_sel = 1; wr_len = l;
    @(negedge clk);
    wr_en = 0; wr_sel = 0;
  endtask

  task automatic xlate(input string tag, input logic [2:0] s, input logic [11:0] o,
                       input logic [1:0] a, input logic f, input logic [1:0] c,
                       input logic [15:0] pa);
    @(negedge clk);
    req_valid = 1; req_seg = s; req_off = o; req_acc = a;
    @(negedge clk);
    req_valid = 0;
    chk_rsp(tag, f, c, pa);
  endtask

  task automatic t_reset;
    chk("R1 rsp_valid after reset", {31'd0, rsp_valid}, 32'd0);
    chk("R1 req_ready after reset", {31'd0, req_ready}, 32'd1);
    xlate("R1 request after reset", 3'd0, 12'd0, 2'b00, 1'b1, 2'b00, 16'd0);
    @(negedge clk);
    chk("R3 answer consumed", {31'd0, rsp_valid}, 32'd0);
  endtask

  task automatic t_priority;
    put_len(4'd3);
    put_ent(3'd1, 16'h0100, 13'd16, 1'b0, 3'b000);
    put_ent(3'd2, 16'h0200, 13'd16, 1'b1, 3'b000);
    // seg 5 is out of range and its entry is invalid
    xlate("R4 range beats invalid", 3'd5, 12'd100, 2'b01, 1'b1, 2'b00, 16'd0);
    xlate("R4 seg equal to length", 3'd3, 12'd0, 2'b00, 1'b1, 2'b00, 16'd0);
    xlate("R5 invalid beats limit", 3'd1, 12'd100, 2'b11, 1'b1, 2'b01, 16'd0);
    xlate("R6 limit beats perm", 3'd2, 12'd16, 2'b00, 1'b1, 2'b10, 16'd0);
    xlate("R7 no perms", 3'd2, 12'd15, 2'b00, 1'b1, 2'b11, 16'd0);
  endtask

  task automatic t_perm;
    put_ent(3'd0, 16'h1000, 13'd64, 1'b1, 3'b001);
    xlate("R7 read allowed", 3'd0, 12'd4, 2'b00, 1'b0, 2'b00, 16'h1004);
    xlate("R7 write denied", 3'd0, 12'd4, 2'b01, 1'b1, 2'b11, 16'd0);
    xlate("R7 exec denied", 3'd0, 12'd4, 2'b10, 1'b1, 2'b11, 16'd0);
    put_ent(3'd0, 16'h1000, 13'd64, 1'b1, 3'b111);
    xlate("R7 write allowed", 3'd0, 12'd8, 2'b01, 1'b0, 2'b00, 16'h1008);
    xlate("R7 exec allowed", 3'd0, 12'd9, 2'b10, 1'b0, 2'b00, 16'h1009);
    xlate("R7 reserved type denied", 3'd0, 12'd9, 2'b11, 1'b1, 2'b11, 16'd0);
  endtask

  task automatic t_limit_sum;
    put_ent(3'd2, 16'hFFF0, 13'd4096, 1'b1, 3'b001);
    xlate("R6 offset limit-1 ok", 3'd2, 12'hFFF, 2'b00, 1'b0, 2'b00, 16'h0FEF);
    xlate("R8 wrapped sum", 3'd2, 12'h020, 2'b00, 1'b0, 2'b00, 16'h0010);
    put_ent(3'd2, 16'h0300, 13'd5, 1'b1, 3'b001);
    xlate("R6 offset at limit", 3'd2, 12'd5, 2'b00, 1'b1, 2'b10, 16'd0);
    xlate("R8 plain sum", 3'd2, 12'd4, 2'b00, 1'b0, 2'b00, 16'h0304);
  endtask

  task automatic t_stall;
    @(negedge clk);
    rsp_ready = 0; req_valid = 1; req_seg = 3'd2; req_off = 12'd1; req_acc = 2'b00;
    @(negedge clk);
    chk_rsp("R2 first answer", 1'b0, 2'b00, 16'h0301);
    chk("R2 ready low while stalled", {31'd0, req_ready}, 32'd0);
    req_seg = 3'd2; req_off = 12'd3;
    @(negedge clk);
    chk_rsp("R3 held under stall", 1'b0, 2'b00, 16'h0301);
    rsp_ready = 1;
    @(negedge clk);
    req_valid = 0;
    chk_rsp("R3 second request after release", 1'b0, 2'b00, 16'h0303);
    @(negedge clk);
    chk("R3 no duplicate answer", {31'd0, rsp_valid}, 32'd0);
  endtask

  task automatic t_same_edge;
    @(negedge clk);
    wr_en = 1; wr_sel = 0; wr_idx = 3'd2; wr_base = 16'h0800; wr_limit = 13'd5;
    wr_ok = 1; wr_perm = 3'b001;
    req_valid = 1; req_seg = 3'd2; req_off = 12'd2; req_acc = 2'b00;
    @(negedge clk);
    wr_en = 0; req_valid = 0;
    chk_rsp("R9 same-edge uses old base", 1'b0, 2'b00, 16'h0302);
    xlate("R9 later uses new base", 3'd2, 12'd2, 2'b00, 1'b0, 2'b00, 16'h0802);
    put_len(4'd2);
    xlate("R9 shrunk length", 3'd2, 12'd2, 2'b00, 1'b1, 2'b00, 16'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_priority();
    t_perm();
    t_limit_sum();
    t_stall();
    t_same_edge();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule